// File: doc/BRIEF.md
# Bit-Clock to Frame-Sync Ratio Detector

This block works out which bit-clock rate is in use. It counts the bit-clock cycles between successive rising edges of an 8 kHz frame sync, and the frame sync must be synchronous to the bit clock. Each count that is measured is matched against the nine supported rates, which span 256 kHz to 8.192 MHz. The match gives a 3-bit multiplier code for a downstream clock synthesizer.

After reset the block waits until two consecutive frames give the same count. It then latches the code for that count once and keeps it until the next reset. Software can overwrite the code at any time through a write port.

Every load of the multiplier code starts a settle interval, counted in bit-clock cycles. This interval stands in for the time the synthesizer needs to lock. The valid output goes high only after a code has been latched and the settle interval has run out. An agreed count that matches no supported rate raises an error flag and leaves the code as it was.

Top module: `pclk_ratio_detect`

## Requirements
- R1: While `rst_n` is low at a rising edge of `pclk`, the outputs clear on that edge: `mult_code` = 0, `code_valid` = 0, `ratio_err` = 0 and `settling` = 0.
- R2: A rising edge of `fsync` is detected in the first `pclk` cycle in which `fsync` is sampled high after being sampled low. The measured count is the number of `pclk` cycles from one detected edge to the next. The counter is $clog2(MAX_COUNT)+2 bits wide and saturates at all-ones instead of wrapping (4095 with the default MAX_COUNT = 1024).
- R3: Supported counts map to these codes: 32→0, 64→1, 96→2, 128→3, 192→4, 193→4, 256→5, 512→6, 1024→7.
- R4: A measurement is acted on only when it equals the measurement from the frame before. The first measurement after reset is never acted on. When two consecutive measurements agree at the edge that ends a frame, the resulting `mult_code` appears two `pclk` edges after that frame-sync edge.
- R5: If two consecutive measurements agree on a count that is not supported, `ratio_err` goes high and `mult_code` does not change. A later agreeing measurement of a supported count clears `ratio_err`. Measurements that do not agree leave `ratio_err` unchanged.
- R6: Once a code has been loaded, either by detection or by a write, detection no longer changes `mult_code` until the next reset.
- R7: When `wr_en` is high at a `pclk` edge, `wr_code` is loaded into `mult_code` on that edge. A write takes priority over detection in the same cycle, and it counts as a load.
- R8: Every load drives `settling` high for exactly SETTLE_CYCLES `pclk` cycles, starting with the loading edge. `code_valid` is high exactly when a code has been loaded and `settling` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bit clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | 8 kHz frame sync, synchronous to pclk |
| wr_en | input | 1 | Software write strobe for the multiplier code |
| wr_code | input | 3 | Code loaded when wr_en is high |
| mult_code | output | 3 | Multiplier code driving the clock synthesizer |
| code_valid | output | 1 | Code loaded and settle interval over |
| ratio_err | output | 1 | Last agreed count matched no supported rate |
| settling | output | 1 | Settle interval running |

## Verification
The bench builds the block with SETTLE_CYCLES = 20, so that the rise of `code_valid` comes inside a single 32-cycle frame. It also checks that a write made during a settle interval restarts the full interval. MAX_COUNT keeps its default of 1024, which makes the counter 12 bits wide. A 4160-cycle frame therefore separates saturation from wrap-around: a wrapping counter would read 64 and lock code 1, while a saturating one reads 4095 and raises the error. Every supported rate is applied once from reset, with the partial first frame left in place.

// File: rtl/clkr_pkg.sv
// Package: clkr_pkg
// Shared constants for the bit-clock ratio detector. Holds the table of
// supported per-frame counts and the code each one maps to. Assumes the
// table is listed in ascending order of count.
package clkr_pkg;
    localparam int CODE_W    = 3;
    localparam int NUM_RATES = 9;

    localparam int RATE_COUNT [NUM_RATES] = '{32, 64, 96, 128, 192, 193, 256, 512, 1024};
    localparam logic [CODE_W-1:0] RATE_CODE [NUM_RATES] =
        '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 3'd5, 3'd6, 3'd7};
endpackage

// File: rtl/clkr_frame_counter.sv
// Module: clkr_frame_counter
// Counts pclk cycles between rising edges of fsync, sampled in the pclk
// domain. On each detected edge it captures the running count and pulses
// meas_stb for one cycle. The counter saturates so that a very long frame
// cannot alias onto a supported count. Assumes fsync is synchronous to pclk.
module clkr_frame_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [CNT_W-1:0] meas,
    output logic             meas_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             fs_q;
    logic             fs_edge;
    logic [CNT_W-1:0] run_cnt;

    assign fs_edge = fsync & ~fs_q;

    // Purpose: remember the previous fsync sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fsync;
    end

    // Purpose: saturating cycle counter that restarts at one on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_cnt <= '0;
        else if (fs_edge)          run_cnt <= CNT_W'(1);
        else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + CNT_W'(1);
    end

    // Purpose: capture the count that ended at this edge and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas     <= '0;
            meas_stb <= 1'b0;
        end else begin
            meas_stb <= fs_edge;
            if (fs_edge) meas <= run_cnt;
        end
    end

    p_edge_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fs_edge |=> (meas_stb && run_cnt == CNT_W'(1)));

    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == CNT_MAX && !fs_edge) |=> (run_cnt == CNT_MAX));
endmodule

// File: rtl/clkr_classifier.sv
// Module: clkr_classifier
// Compares a measured count against every supported per-frame count, using
// one comparator per table entry. Reports whether any entry matched and the
// code of the matching entry. Purely combinational. Assumes the table
// entries are distinct, so at most one comparator can hit.
module clkr_classifier
    import clkr_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]  meas,
    output logic              hit_any,
    output logic [CODE_W-1:0] hit_code
);
    logic [NUM_RATES-1:0] hit;

    for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_cmp
        assign hit[gi] = (meas == CNT_W'(RATE_COUNT[gi]));
    end

    assign hit_any = |hit;

    // Purpose: fold the one-hot hit vector into its table code.
    always_comb begin
        hit_code = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (hit[i]) hit_code = hit_code | RATE_CODE[i];
        end
    end

    always_comb begin
        p_single_hit_r3: assert ($onehot0(hit));
    end
endmodule

// File: rtl/clkr_code_latch.sv
// Module: clkr_code_latch
// Holds the multiplier code. It acts on a measurement only when that
// measurement agrees with the one from the previous frame. The first agreed
// supported count is latched once. An agreed unsupported count sets the
// error flag. A software write overrides detection. Produces a load pulse
// for the settle timer. Assumes meas_stb lasts one cycle per frame.
module clkr_code_latch
    import clkr_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  meas,
    input  logic              meas_stb,
    input  logic              hit_any,
    input  logic [CODE_W-1:0] hit_code,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code,
    output logic              locked,
    output logic              err,
    output logic              load
);
    logic [CNT_W-1:0] prev_meas;
    logic             have_prev;
    logic             agree;
    logic             det_load;

    assign agree    = meas_stb && have_prev && (meas == prev_meas);
    assign det_load = agree && hit_any && !locked;
    assign load     = wr_en || det_load;

    // Purpose: keep the previous frame's measurement for the agreement test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_meas <= '0;
            have_prev <= 1'b0;
        end else if (meas_stb) begin
            prev_meas <= meas;
            have_prev <= 1'b1;
        end
    end

    // Purpose: error flag follows whether each agreed count is supported.
    always_ff @(posedge clk) begin
        if (!rst_n)     err <= 1'b0;
        else if (agree) err <= !hit_any;
    end

    // Purpose: load the code by write, or once by detection after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code   <= '0;
            locked <= 1'b0;
        end else if (wr_en) begin
            code   <= wr_code;
            locked <= 1'b1;
        end else if (det_load) begin
            code   <= hit_code;
            locked <= 1'b1;
        end
    end

    p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !wr_en) |=> $stable(code));

    p_err_needs_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !agree |=> $stable(err));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (code == $past(wr_code) && locked));
endmodule

// File: rtl/clkr_settle_timer.sv
// Module: clkr_settle_timer
// Models the synthesizer settle wait as a down-counter in pclk cycles. A load
// reloads the full interval, and busy stays high while the count is nonzero.
// Assumes SETTLE_CYCLES is at least one.
module clkr_settle_timer #(
    parameter int SETTLE_CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int ST_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [ST_W-1:0] ST_LOAD = ST_W'(SETTLE_CYCLES);

    logic [ST_W-1:0] remain;

    // Purpose: reload on every load, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain <= '0;
        else if (load)          remain <= ST_LOAD;
        else if (remain != '0)  remain <= remain - ST_W'(1);
    end

    assign busy = (remain != '0);

    p_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (remain == $past(remain) - ST_W'(1)));
endmodule

// File: rtl/pclk_ratio_detect.sv
// Module: pclk_ratio_detect
// Top of the bit-clock ratio detector. Measures pclk cycles per fsync frame,
// classifies the count into a 3-bit multiplier code, latches it after two
// agreeing frames, and holds off valid for a settle interval after each load.
// Assumes fsync is synchronous to pclk and MAX_COUNT is at least 1024.
module pclk_ratio_detect
    import clkr_pkg::*;
#(
    parameter int MAX_COUNT     = 1024,
    parameter int SETTLE_CYCLES = 512
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] mult_code,
    output logic              code_valid,
    output logic              ratio_err,
    output logic              settling
);
    localparam int CNT_W = $clog2(MAX_COUNT) + 2;

    logic [CNT_W-1:0]  meas;
    logic              meas_stb;
    logic              hit_any;
    logic [CODE_W-1:0] hit_code;
    logic              locked;
    logic              load;

    clkr_frame_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (pclk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .meas     (meas),
        .meas_stb (meas_stb)
    );

    clkr_classifier #(.CNT_W(CNT_W)) u_class (
        .meas     (meas),
        .hit_any  (hit_any),
        .hit_code (hit_code)
    );

    clkr_code_latch #(.CNT_W(CNT_W)) u_latch (
        .clk      (pclk),
        .rst_n    (rst_n),
        .meas     (meas),
        .meas_stb (meas_stb),
        .hit_any  (hit_any),
        .hit_code (hit_code),
        .wr_en    (wr_en),
        .wr_code  (wr_code),
        .code     (mult_code),
        .locked   (locked),
        .err      (ratio_err),
        .load     (load)
    );

    clkr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (pclk),
        .rst_n (rst_n),
        .load  (load),
        .busy  (settling)
    );

    assign code_valid = locked && !settling;

    p_change_settles_r8: assert property (@(posedge pclk) disable iff (!rst_n)
        !$stable(mult_code) |-> settling);

    p_valid_quiet_code_r6: assert property (@(posedge pclk) disable iff (!rst_n)
        (code_valid && !wr_en) |=> $stable(mult_code));
endmodule

// File: tb/tb_pclk_ratio_detect.sv
// Bench for pclk_ratio_detect. A behavioural reference model advances on
// every rising edge, and the bench compares it with the outputs on every
// falling edge. Scenario checks tagged by requirement are added on top.
module tb_pclk_ratio_detect;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 20;
    localparam int SAT        = 4095;

    logic       pclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_code = 3'd0;
    logic [2:0] mult_code;
    logic       code_valid, ratio_err, settling;

    int n_checks = 0;
    int n_fail   = 0;

    pclk_ratio_detect #(.MAX_COUNT(1024), .SETTLE_CYCLES(SETTLE)) dut (
        .pclk(pclk), .rst_n(rst_n), .fsync(fsync), .wr_en(wr_en),
        .wr_code(wr_code), .mult_code(mult_code), .code_valid(code_valid),
        .ratio_err(ratio_err), .settling(settling)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    // Reference model state
    int m_code, m_settle, m_prev, m_pend, m_cyc;
    bit m_locked, m_err, m_have, m_pstb, m_fsq;

    function automatic int rate_code(input int c);
        case (c)
            32: return 0;     64: return 1;     96: return 2;
            128: return 3;    192: return 4;    193: return 4;
            256: return 5;    512: return 6;    1024: return 7;
            default: return -1;
        endcase
    endfunction

    always @(posedge pclk) begin
        if (!rst_n) begin
            m_code = 0; m_settle = 0; m_prev = 0; m_pend = 0; m_cyc = 0;
            m_locked = 0; m_err = 0; m_have = 0; m_pstb = 0; m_fsq = 0;
        end else begin
            bit ld;
            bit ag;
            bit edg;
            int rc;
            ld = 0;
            ag = m_pstb && m_have && (m_pend == m_prev);
            rc = rate_code(m_pend);
            if (ag) m_err = (rc < 0);
            if (wr_en) begin
                m_code = int'(wr_code); m_locked = 1; ld = 1;
            end else if (ag && rc >= 0 && !m_locked) begin
                m_code = rc; m_locked = 1; ld = 1;
            end
            if (m_pstb) begin m_prev = m_pend; m_have = 1; end
            if (ld) m_settle = SETTLE;
            else if (m_settle > 0) m_settle = m_settle - 1;
            edg = fsync && !m_fsq;
            m_fsq = fsync;
            m_pstb = edg;
            if (edg) begin m_pend = m_cyc; m_cyc = 1; end
            else if (m_cyc < SAT) m_cyc = m_cyc + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge pclk) begin
        if (rst_n) begin
            chk("R3 R7 mult_code vs model", int'(mult_code), m_code);
            chk("R5 ratio_err vs model", int'(ratio_err), int'(m_err));
            chk("R8 settling vs model", int'(settling), int'(m_settle != 0));
            chk("R8 code_valid vs model", int'(code_valid), int'(m_locked && m_settle == 0));
        end
    end

    task automatic do_reset();
        @(negedge pclk);
        rst_n = 1'b0; fsync = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge pclk);
        rst_n = 1'b1;
    endtask

    task automatic frame(input int p);
        fsync = 1'b1;
        @(negedge pclk);
        fsync = 1'b0;
        repeat (p - 1) @(negedge pclk);
    endtask

    task automatic frames(input int p, input int n);
        for (int i = 0; i < n; i++) frame(p);
    endtask

    task automatic detect_case(input int p, input int code, input string tag);
        do_reset();
        frames(p, 3);
        repeat (SETTLE + 2) @(negedge pclk);
        chk(tag, int'(mult_code), code);
        chk(tag, int'(code_valid), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge pclk);
        chk("R1 mult_code in reset", int'(mult_code), 0);
        chk("R1 code_valid in reset", int'(code_valid), 0);
        chk("R1 ratio_err in reset", int'(ratio_err), 0);
        chk("R1 settling in reset", int'(settling), 0);
        rst_n = 1'b1;

        // R4: partial first frame plus one full frame gives no lock
        frames(64, 2);
        chk("R4 no lock after one agreement chance", int'(settling), 0);
        chk("R4 valid low before agreement", int'(code_valid), 0);
        // third edge: code appears two edges after it
        fsync = 1'b1;
        @(negedge pclk); fsync = 1'b0;
        chk("R4 latency edge+1", int'(settling), 0);
        @(negedge pclk);
        chk("R4 latency edge+2 code", int'(mult_code), 1);
        chk("R8 settling on load", int'(settling), 1);
        repeat (62) @(negedge pclk);
        chk("R3 64 -> 1", int'(mult_code), 1);
        chk("R8 valid after settle", int'(code_valid), 1);

        // R6: a different agreed rate after lock does not change the code
        frames(128, 4);
        chk("R6 code held after lock", int'(mult_code), 1);

        // R7: write overrides, restarts settle
        wr_code = 3'd6; wr_en = 1'b1;
        @(negedge pclk); wr_en = 1'b0;
        chk("R7 write loads code", int'(mult_code), 6);
        chk("R7 write restarts settle", int'(code_valid), 0);
        repeat (10) @(negedge pclk);
        wr_code = 3'd3; wr_en = 1'b1;
        @(negedge pclk); wr_en = 1'b0;
        repeat (SETTLE - 2) @(negedge pclk);
        chk("R8 rewrite restarts full interval", int'(settling), 1);
        repeat (4) @(negedge pclk);
        chk("R8 valid after rewrite settle", int'(code_valid), 1);
        chk("R7 second write code", int'(mult_code), 3);

        // R5: unsupported agreed count raises error, code kept
        do_reset();
        frames(100, 3);
        repeat (3) @(negedge pclk);
        chk("R5 error on unsupported", int'(ratio_err), 1);
        chk("R5 code unchanged on error", int'(mult_code), 0);
        chk("R5 not valid on error", int'(code_valid), 0);
        frames(96, 3);
        repeat (SETTLE + 2) @(negedge pclk);
        chk("R5 error cleared by supported", int'(ratio_err), 0);
        chk("R3 96 -> 2", int'(mult_code), 2);
        frames(100, 3);
        chk("R5 error after lock", int'(ratio_err), 1);
        chk("R5 locked code kept", int'(mult_code), 2);

        // R3: every supported count from reset
        detect_case(32,   0, "R3 32 -> 0");
        detect_case(128,  3, "R3 128 -> 3");
        detect_case(192,  4, "R3 192 -> 4");
        detect_case(193,  4, "R3 193 -> 4");
        detect_case(256,  5, "R3 256 -> 5");
        detect_case(512,  6, "R3 512 -> 6");
        detect_case(1024, 7, "R3 1024 -> 7");

        // R4: alternating counts never agree
        do_reset();
        for (int i = 0; i < 4; i++) begin frame(64); frame(128); end
        chk("R4 alternating no lock code", int'(mult_code), 0);
        chk("R4 alternating no valid", int'(code_valid), 0);
        chk("R4 alternating no error", int'(ratio_err), 0);

        // R2: saturation, a wrapping counter would read 64
        do_reset();
        frames(4160, 3);
        repeat (3) @(negedge pclk);
        chk("R2 saturated count flags error", int'(ratio_err), 1);
        chk("R2 saturated count no lock", int'(settling), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule